// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block sits between a processor and a slower line-oriented memory. It holds 1 KB of data as 32 lines of 32 bytes, with one line per index. The processor issues byte-addressed, word-aligned 32-bit loads and stores, and stores carry four byte enables. Each address is split into a byte select, a line index and a tag. The controller checks the single line that the index names and reports whether the access hit.

A miss holds the processor off until the access has been served. A miss that needs the line fetches it from memory. If the line being replaced holds modified data, that line is first written back to memory as a whole. Two elaboration-time switches choose the store behaviour:
- `WRITE_BACK` selects write-back with per-line dirty bits, or write-through.
- `WRITE_ALLOC` selects whether a store miss fetches the line first, or goes straight to memory and leaves the cache untouched.

The memory side moves whole lines through a request/ready handshake. A single-word store travels on the same port as a line transfer, with only that word's four byte lanes enabled.

Top module: `dmc_cache`

## Requirements
- R1: Address bits 4:0 select the byte in a line (bits 4:2 the word, bits 1:0 must be zero), bits 9:5 select one of 32 lines, and bits 31:10 form the tag. Addresses that differ only in bits 4:0 share a line. Addresses with the same index and a different tag conflict.
- R2: Reset clears every valid bit, so the first access to any address misses (`cpu_hit`=0).
- R3: A load to a valid line whose tag matches completes in the cycle it is presented: `cpu_ready`=1 and `cpu_hit`=1 in that cycle, the word is returned, and there is no memory traffic.
- R4: A load miss fetches exactly one line (a `mem_req` with `mem_we`=0) and replaces the current occupant of that index. It then returns the requested word with `cpu_hit`=0. `cpu_ready` stays low until the fetch is complete.
- R5: In write-back mode, a store hit updates the cache only, marks the line dirty, and causes no memory write.
- R6: In write-back mode, a miss on an index whose line is dirty first writes that whole line to the victim's address (`mem_we`=1, all 32 bits of `mem_be` set), and then fetches. A clean victim is not written back.
- R7: In write-through mode, every store sends one word write to memory, with only that word's four lanes of `mem_be` set. The cached copy is updated when the line is present. No whole-line write ever occurs.
- R8: With write-allocate, a store miss fetches the line and then merges the store into it. Later loads of that line hit.
- R9: With no-allocate, a store miss performs only the memory word write and leaves the cache unchanged, so a later load of that address misses and returns the stored value.
- R10: Only the bytes whose `cpu_be` bit is set change, in the cache and in memory. Bit k of `cpu_be` covers data bits 8k+7:8k.
- R11: Once raised, `mem_req` and its address and direction are held until `mem_ready`. After reset `mem_req` is low.
- R12: `cpu_ready` is high only while `cpu_req` is high. The request must be held until `cpu_ready`. `cpu_hit` is meaningful when `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address, word aligned |
| cpu_be | input | 4 | Byte enables for stores |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_hit | output | 1 | The completing access was a hit |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write to memory, 0 = line fetch |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_be | output | 32 | Byte lane enables over the line |
| mem_wdata | output | 256 | Write line data |
| mem_ready | input | 1 | Memory completes the transfer at this edge |
| mem_rdata | input | 256 | Fetched line, valid with mem_ready |

## Verification
The hardest case to reach is a dirty victim. It needs a store hit on a resident line, followed by a miss to the same index under a different tag, and it must be observed through the memory model's write counter and its contents. The directed part builds exactly that chain on index 0 and then touches a third tag to confirm that a clean victim is not written back. Random traffic confined to a few tags and eight indices keeps conflicts frequent in both policy builds. The whole write-through memory image is compared against the reference afterwards.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    localparam int ADDR_W         = 32;
    localparam int WORD_W         = 32;
    localparam int CACHE_BYTES    = 1024;
    localparam int LINE_BYTES     = 32;
    localparam int WORD_BYTES     = WORD_W / 8;
    localparam int OFF_W          = $clog2(LINE_BYTES);
    localparam int NUM_LINES      = CACHE_BYTES / LINE_BYTES;
    localparam int IDX_W          = $clog2(NUM_LINES);
    localparam int TAG_W          = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W         = LINE_BYTES * 8;
    localparam int WORDS_PER_LINE = LINE_BYTES / WORD_BYTES;
    localparam int WSEL_W         = $clog2(WORDS_PER_LINE);
    localparam int LANE_W         = $clog2(WORD_BYTES);

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [WSEL_W-1:0] wsel;
        logic [LANE_W-1:0] lane;
    } addr_split_t;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2,
        ST_WORDWR = 2'd3
    } ctl_state_e;

    typedef logic [LINE_W-1:0]     line_t;
    typedef logic [LINE_BYTES-1:0] line_mask_t;
    typedef logic [TAG_W-1:0]      tag_t;

    function automatic line_t spread_word(logic [WSEL_W-1:0] wsel, logic [WORD_W-1:0] w);
        line_t r;
        r = '0;
        r[int'(wsel)*WORD_W +: WORD_W] = w;
        return r;
    endfunction

    function automatic line_mask_t lane_mask(logic [WSEL_W-1:0] wsel, logic [WORD_BYTES-1:0] be);
        line_mask_t m;
        m = '0;
        m[int'(wsel)*WORD_BYTES +: WORD_BYTES] = be;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] pick_word(line_t l, logic [WSEL_W-1:0] wsel);
        return l[int'(wsel)*WORD_W +: WORD_W];
    endfunction

    function automatic logic [ADDR_W-1:0] line_base(tag_t tag, logic [IDX_W-1:0] idx);
        return {tag, idx, {OFF_W{1'b0}}};
    endfunction
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store
    import dmc_pkg::*;
#(
    parameter int N_LINES = NUM_LINES,
    parameter int IW      = IDX_W,
    parameter int TW      = TAG_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] idx,
    output logic          line_valid,
    output logic          line_dirty,
    output logic [TW-1:0] line_tag,
    input  logic          fill_en,
    input  logic [TW-1:0] fill_tag,
    input  logic          mark_dirty
);
    logic [N_LINES-1:0] valid_q;
    logic [N_LINES-1:0] dirty_q;
    logic [TW-1:0]      tag_q [N_LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tag_q[idx] <= fill_tag;
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
    assign line_tag   = tag_q[idx];

    // R4: a fill leaves the line valid and clean
    assert_fill_clean_R4: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> valid_q[$past(idx)] && !dirty_q[$past(idx)]);

    // R5: dirty marking only on a resident line
    assert_dirty_valid_R5: assert property (@(posedge clk) disable iff (rst)
        mark_dirty |-> valid_q[idx]);
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store
    import dmc_pkg::*;
#(
    parameter int N_LINES = NUM_LINES,
    parameter int IW      = IDX_W,
    parameter int LBYTES  = LINE_BYTES
) (
    input  logic              clk,
    input  logic [IW-1:0]     idx,
    output logic [LBYTES*8-1:0] rd_line,
    input  logic              wr_en,
    input  logic [LBYTES-1:0] wr_mask,
    input  logic [LBYTES*8-1:0] wr_line
);
    localparam int LW = LBYTES * 8;

    logic [LW-1:0] line_q [N_LINES];
    logic [LW-1:0] merged;

    assign rd_line = line_q[idx];

    for (genvar b = 0; b < LBYTES; b++) begin : g_byte
        assign merged[b*8 +: 8] = wr_mask[b] ? wr_line[b*8 +: 8] : rd_line[b*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (wr_en) line_q[idx] <= merged;
    end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_req,
    input  logic       cpu_we,
    input  logic       lookup_hit,
    input  logic       victim_dirty,
    input  logic       mem_ready,
    output ctl_state_e state,
    output logic       cpu_ready,
    output logic       cpu_hit,
    output logic       mem_req,
    output logic       mem_we,
    output logic       fill_en,
    output logic       cpu_wr_en,
    output logic       mark_dirty
);
    ctl_state_e state_q, state_d;
    logic       missed_q, missed_d;

    always_comb begin
        state_d    = state_q;
        missed_d   = missed_q;
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        fill_en    = 1'b0;
        cpu_wr_en  = 1'b0;
        mark_dirty = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                if (cpu_req) begin
                    if (lookup_hit) begin
                        if (!cpu_we) begin
                            cpu_ready = 1'b1;
                        end else if (WRITE_BACK) begin
                            cpu_ready  = 1'b1;
                            cpu_wr_en  = 1'b1;
                            mark_dirty = 1'b1;
                        end else begin
                            state_d = ST_WORDWR;
                        end
                    end else if (cpu_we && !WRITE_ALLOC) begin
                        missed_d = 1'b1;
                        state_d  = ST_WORDWR;
                    end else begin
                        missed_d = 1'b1;
                        state_d  = (WRITE_BACK && victim_dirty) ? ST_EVICT : ST_REFILL;
                    end
                end
            end
            ST_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) state_d = ST_REFILL;
            end
            ST_REFILL: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    fill_en = 1'b1;
                    state_d = ST_LOOKUP;
                end
            end
            ST_WORDWR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) begin
                    cpu_ready = 1'b1;
                    cpu_wr_en = lookup_hit;
                    state_d   = ST_LOOKUP;
                end
            end
            default: state_d = ST_LOOKUP;
        endcase
        if (cpu_ready) missed_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_LOOKUP;
            missed_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            missed_q <= missed_d;
        end
    end

    assign state   = state_q;
    assign cpu_hit = cpu_ready && !missed_q;

    // R11: an outstanding memory transfer is not abandoned
    assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(state_q));

    // R12: completion only for a live request
    assert_ready_req_R12: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> cpu_req);

    // R6: a victim writeback is always followed by the fetch
    assert_evict_refill_R6: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_EVICT && mem_ready |=> state_q == ST_REFILL);

    // R5: write-back with allocation never issues a word write
    assert_wb_no_word_R5: assert property (@(posedge clk) disable iff (rst)
        !(WRITE_BACK && WRITE_ALLOC) || state_q != ST_WORDWR);
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter bit WRITE_BACK  = 1'b1,
    parameter bit WRITE_ALLOC = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_req,
    input  logic                  cpu_we,
    input  logic [ADDR_W-1:0]     cpu_addr,
    input  logic [WORD_BYTES-1:0] cpu_be,
    input  logic [WORD_W-1:0]     cpu_wdata,
    output logic                  cpu_ready,
    output logic                  cpu_hit,
    output logic [WORD_W-1:0]     cpu_rdata,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LINE_BYTES-1:0] mem_be,
    output logic [LINE_W-1:0]     mem_wdata,
    input  logic                  mem_ready,
    input  logic [LINE_W-1:0]     mem_rdata
);
    addr_split_t req_a;
    ctl_state_e  state;
    logic        line_valid, line_dirty, lookup_hit;
    tag_t        line_tag;
    line_t       cur_line;
    logic        fill_en, cpu_wr_en, mark_dirty;
    logic        data_wr_en;
    line_mask_t  data_mask, word_mask;
    line_t       data_line, word_line;

    assign req_a      = cpu_addr;
    assign lookup_hit = line_valid && (line_tag == req_a.tag);
    assign word_mask  = lane_mask(req_a.wsel, cpu_be);
    assign word_line  = spread_word(req_a.wsel, cpu_wdata);

    dmc_tag_store #(.N_LINES(NUM_LINES), .IW(IDX_W), .TW(TAG_W)) u_tags (
        .clk        (clk),
        .rst        (rst),
        .idx        (req_a.idx),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .fill_en    (fill_en),
        .fill_tag   (req_a.tag),
        .mark_dirty (mark_dirty)
    );

    assign data_wr_en = fill_en || cpu_wr_en;
    assign data_mask  = fill_en ? '1 : word_mask;
    assign data_line  = fill_en ? mem_rdata : word_line;

    dmc_data_store #(.N_LINES(NUM_LINES), .IW(IDX_W), .LBYTES(LINE_BYTES)) u_data (
        .clk     (clk),
        .idx     (req_a.idx),
        .rd_line (cur_line),
        .wr_en   (data_wr_en),
        .wr_mask (data_mask),
        .wr_line (data_line)
    );

    dmc_ctrl #(.WRITE_BACK(WRITE_BACK), .WRITE_ALLOC(WRITE_ALLOC)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .lookup_hit   (lookup_hit),
        .victim_dirty (line_valid && line_dirty),
        .mem_ready    (mem_ready),
        .state        (state),
        .cpu_ready    (cpu_ready),
        .cpu_hit      (cpu_hit),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .fill_en      (fill_en),
        .cpu_wr_en    (cpu_wr_en),
        .mark_dirty   (mark_dirty)
    );

    assign cpu_rdata = pick_word(cur_line, req_a.wsel);

    always_comb begin
        unique case (state)
            ST_EVICT: begin
                mem_addr  = line_base(line_tag, req_a.idx);
                mem_wdata = cur_line;
                mem_be    = '1;
            end
            ST_WORDWR: begin
                mem_addr  = line_base(req_a.tag, req_a.idx);
                mem_wdata = word_line;
                mem_be    = word_mask;
            end
            default: begin
                mem_addr  = line_base(req_a.tag, req_a.idx);
                mem_wdata = word_line;
                mem_be    = '0;
            end
        endcase
    end

    // R1: accesses are word aligned
    assert_aligned_R1: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> req_a.lane == '0);

    // R11: address and direction stay put while memory is busy
    assert_mem_stable_R11: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> $stable(mem_addr) && $stable(mem_we));

    // R7: write-through never writes more than one word
    assert_wt_word_R7: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> WRITE_BACK || ($countones(mem_be) <= WORD_BYTES));
endmodule

// File: tb/dmc_cache_bench.sv
module dmc_mem_model #(
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic         we,
    input  logic [31:0]  addr,
    input  logic [31:0]  be,
    input  logic [255:0] wdata,
    output logic         ready,
    output logic [255:0] rdata,
    output int           n_rd,
    output int           n_wl,
    output int           n_ww
);
    logic [255:0] mem_q [128];
    int cnt;

    function automatic logic [31:0] initw(int wa);
        return {16'hC0DE ^ wa[15:0], wa[15:0]};
    endfunction

    assign ready = req && (cnt == LAT);
    assign rdata = mem_q[addr[11:5]];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= 0; n_rd <= 0; n_wl <= 0; n_ww <= 0;
            for (int l = 0; l < 128; l++)
                for (int w = 0; w < 8; w++)
                    mem_q[l][w*32 +: 32] <= initw(l*8 + w);
        end else if (req) begin
            if (cnt == LAT) begin
                cnt <= 0;
                if (we) begin
                    for (int b = 0; b < 32; b++)
                        if (be[b]) mem_q[addr[11:5]][b*8 +: 8] <= wdata[b*8 +: 8];
                    if (be == '1) n_wl <= n_wl + 1;
                    else n_ww <= n_ww + 1;
                end else begin
                    n_rd <= n_rd + 1;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            cnt <= 0;
        end
    end
endmodule

module dmc_cache_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic         cpu_req [2];
    logic         cpu_we [2];
    logic [31:0]  cpu_addr [2];
    logic [3:0]   cpu_be [2];
    logic [31:0]  cpu_wdata [2];
    logic         cpu_ready [2];
    logic         cpu_hit [2];
    logic [31:0]  cpu_rdata [2];
    logic         mem_req [2];
    logic         mem_we [2];
    logic [31:0]  mem_addr [2];
    logic [31:0]  mem_be [2];
    logic [255:0] mem_wdata [2];
    logic         mem_ready [2];
    logic [255:0] mem_rdata [2];
    int           n_rd [2];
    int           n_wl [2];
    int           n_ww [2];

    // configuration 0: write-back, write-allocate
    dmc_cache #(.WRITE_BACK(1'b1), .WRITE_ALLOC(1'b1)) u_dmc_cache (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]), .cpu_addr(cpu_addr[0]),
        .cpu_be(cpu_be[0]), .cpu_wdata(cpu_wdata[0]), .cpu_ready(cpu_ready[0]),
        .cpu_hit(cpu_hit[0]), .cpu_rdata(cpu_rdata[0]),
        .mem_req(mem_req[0]), .mem_we(mem_we[0]), .mem_addr(mem_addr[0]),
        .mem_be(mem_be[0]), .mem_wdata(mem_wdata[0]), .mem_ready(mem_ready[0]),
        .mem_rdata(mem_rdata[0]));

    // configuration 1: write-through, no-allocate
    dmc_cache #(.WRITE_BACK(1'b0), .WRITE_ALLOC(1'b0)) u_dmc_cache_wt (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]), .cpu_addr(cpu_addr[1]),
        .cpu_be(cpu_be[1]), .cpu_wdata(cpu_wdata[1]), .cpu_ready(cpu_ready[1]),
        .cpu_hit(cpu_hit[1]), .cpu_rdata(cpu_rdata[1]),
        .mem_req(mem_req[1]), .mem_we(mem_we[1]), .mem_addr(mem_addr[1]),
        .mem_be(mem_be[1]), .mem_wdata(mem_wdata[1]), .mem_ready(mem_ready[1]),
        .mem_rdata(mem_rdata[1]));

    dmc_mem_model u_mem0 (.clk(clk), .rst(rst), .req(mem_req[0]), .we(mem_we[0]),
        .addr(mem_addr[0]), .be(mem_be[0]), .wdata(mem_wdata[0]), .ready(mem_ready[0]),
        .rdata(mem_rdata[0]), .n_rd(n_rd[0]), .n_wl(n_wl[0]), .n_ww(n_ww[0]));
    dmc_mem_model u_mem1 (.clk(clk), .rst(rst), .req(mem_req[1]), .we(mem_we[1]),
        .addr(mem_addr[1]), .be(mem_be[1]), .wdata(mem_wdata[1]), .ready(mem_ready[1]),
        .rdata(mem_rdata[1]), .n_rd(n_rd[1]), .n_wl(n_wl[1]), .n_ww(n_ww[1]));

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] ref_q [2][1024];
    bit          sv_valid [2][32];
    int          sv_tag [2][32];

    function automatic logic [31:0] initw(int wa);
        return {16'hC0DE ^ wa[15:0], wa[15:0]};
    endfunction

    function automatic logic [31:0] memword(int c, logic [31:0] a);
        if (c == 0) return u_mem0.mem_q[a[11:5]][int'(a[4:2])*32 +: 32];
        return u_mem1.mem_q[a[11:5]][int'(a[4:2])*32 +: 32];
    endfunction

    function automatic logic [31:0] merge_be(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic op(input int c, input bit we, input logic [31:0] a, input logic [3:0] be,
                      input logic [31:0] wd, input string rq, output logic [31:0] rd);
        int  idx = int'(a[9:5]);
        int  tg  = int'(a[31:10]);
        int  wa  = int'(a[11:2]);
        bit  exp_hit = sv_valid[c][idx] && (sv_tag[c][idx] == tg);
        bit  got = 0;
        bit  h = 0;
        int  n = 0;
        rd = '0;
        @(negedge clk);
        cpu_req[c] = 1'b1; cpu_we[c] = we; cpu_addr[c] = a; cpu_be[c] = be; cpu_wdata[c] = wd;
        while (!got && n < 3000) begin
            #4;
            if (cpu_ready[c]) begin got = 1; rd = cpu_rdata[c]; h = cpu_hit[c]; end
            @(negedge clk);
            n++;
        end
        cpu_req[c] = 1'b0;
        chk(got, rq, "access completed", 32'(got), 32'd1);
        chk(h == exp_hit, rq, "hit flag", 32'(h), 32'(exp_hit));
        if (!we) chk(rd == ref_q[c][wa], rq, "load data", rd, ref_q[c][wa]);
        else ref_q[c][wa] = merge_be(ref_q[c][wa], wd, be);
        if (!we || c == 0) begin sv_valid[c][idx] = 1; sv_tag[c][idx] = tg; end
    endtask

    initial begin
        logic [31:0] rd;
        int b_rd, b_wl, b_ww;
        int seed;
        for (int c = 0; c < 2; c++) begin
            cpu_req[c] = 0; cpu_we[c] = 0; cpu_addr[c] = 0; cpu_be[c] = 0; cpu_wdata[c] = 0;
            for (int i = 0; i < 1024; i++) ref_q[c][i] = initw(i);
            for (int i = 0; i < 32; i++) begin sv_valid[c][i] = 0; sv_tag[c][i] = 0; end
        end
        seed = $urandom(32'h5EED);
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        #4;
        chk(cpu_ready[0] == 0 && cpu_ready[1] == 0, "R12", "ready idle after reset", 32'(cpu_ready[0]), 0);
        chk(mem_req[0] == 0 && mem_req[1] == 0, "R11", "mem_req idle after reset", 32'(mem_req[0]), 0);

        // ---- write-back / allocate ----
        b_rd = n_rd[0];
        op(0, 0, 32'h004, 4'h0, 0, "R2", rd);
        chk(n_rd[0] == b_rd + 1, "R4", "one line fetch on miss", n_rd[0] - b_rd, 1);
        b_rd = n_rd[0];
        op(0, 0, 32'h01C, 4'h0, 0, "R3", rd);
        chk(n_rd[0] == b_rd && n_wl[0] == 0, "R3", "no traffic on hit", n_rd[0] - b_rd, 0);
        op(0, 1, 32'h008, 4'hF, 32'hAAAA5555, "R5", rd);
        chk(memword(0, 32'h008) == initw(2), "R5", "memory untouched by write-back hit",
            memword(0, 32'h008), initw(2));
        chk(n_ww[0] == 0 && n_wl[0] == 0, "R5", "no memory write", n_ww[0] + n_wl[0], 0);
        op(0, 1, 32'h008, 4'h3, 32'h1234BEEF, "R10", rd);
        op(0, 0, 32'h008, 4'h0, 0, "R10", rd);
        chk(rd == 32'hAAAABEEF, "R10", "half-word merge", rd, 32'hAAAABEEF);
        b_wl = n_wl[0];
        op(0, 0, 32'h408, 4'h0, 0, "R6", rd);
        chk(n_wl[0] == b_wl + 1, "R6", "dirty victim written back", n_wl[0] - b_wl, 1);
        chk(memword(0, 32'h008) == 32'hAAAABEEF, "R6", "victim data in memory",
            memword(0, 32'h008), 32'hAAAABEEF);
        b_wl = n_wl[0];
        op(0, 0, 32'h808, 4'h0, 0, "R6", rd);
        chk(n_wl[0] == b_wl, "R6", "clean victim not written", n_wl[0] - b_wl, 0);
        op(0, 0, 32'h008, 4'h0, 0, "R4", rd);
        b_rd = n_rd[0];
        op(0, 1, 32'h02C, 4'h4, 32'h00770000, "R8", rd);
        chk(n_rd[0] == b_rd + 1, "R8", "store miss fetches line", n_rd[0] - b_rd, 1);
        op(0, 0, 32'h02C, 4'h0, 0, "R8", rd);
        op(0, 0, 32'h024, 4'h0, 0, "R8", rd);
        chk(n_ww[0] == 0, "R8", "no word write in write-back", n_ww[0], 0);
        op(0, 0, 32'h3E0, 4'h0, 0, "R1", rd);
        op(0, 0, 32'h3FC, 4'h0, 0, "R1", rd);
        op(0, 0, 32'h7E0, 4'h0, 0, "R1", rd);
        op(0, 0, 32'h3E4, 4'h0, 0, "R1", rd);

        // ---- write-through / no-allocate ----
        op(1, 0, 32'h040, 4'h0, 0, "R4", rd);
        b_ww = n_ww[1];
        op(1, 1, 32'h044, 4'hC, 32'hABCD0000, "R7", rd);
        chk(n_ww[1] == b_ww + 1, "R7", "word write on store hit", n_ww[1] - b_ww, 1);
        chk(memword(1, 32'h044) == {16'hABCD, initw(17)[15:0]}, "R7", "memory merged",
            memword(1, 32'h044), {16'hABCD, initw(17)[15:0]});
        op(1, 0, 32'h044, 4'h0, 0, "R7", rd);
        b_rd = n_rd[1];
        b_ww = n_ww[1];
        op(1, 1, 32'h060, 4'hF, 32'h600DF00D, "R9", rd);
        chk(n_rd[1] == b_rd && n_ww[1] == b_ww + 1, "R9", "store miss goes to memory only",
            n_rd[1] - b_rd, 0);
        op(1, 0, 32'h060, 4'h0, 0, "R9", rd);

        // ---- random traffic ----
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < 300; i++) begin
                logic [31:0] a;
                bit we;
                logic [3:0] be;
                string rq;
                int idx, tg;
                a  = ((32'($urandom) % 4) << 10) | ((32'($urandom) % 8) << 5) | ((32'($urandom) % 8) << 2);
                we = bit'($urandom % 2);
                be = 4'($urandom % 15 + 1);
                idx = int'(a[9:5]);
                tg  = int'(a[31:10]);
                if (sv_valid[c][idx] && sv_tag[c][idx] == tg) rq = "R3";
                else if (!we) rq = "R4";
                else rq = (c == 0) ? "R8" : "R9";
                op(c, we, a, be, $urandom, rq, rd);
            end
        end
        begin
            bit same = 1;
            for (int i = 0; i < 1024; i++)
                if (memword(1, 32'(i) << 2) != ref_q[1][i]) same = 0;
            chk(same, "R7", "write-through memory image matches", 32'(same), 1);
        end
        chk(n_wl[1] == 0, "R7", "no whole-line write in write-through", n_wl[1], 0);

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule